// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a binary up-counter made of four-bit stages. Every state bit updates on the same rising clock edge, so no bit ever ripples from another bit. Each stage has three controls, all synchronous and all active-low: a clear, a parallel load from a data bus, and a count condition formed from two active-high enables. A clear overrides a load, and a load overrides counting.

The two enables do different jobs. The shared enable `cnt_en_p` only gates counting. The enable `cnt_en_t` gates counting and also qualifies the carry. Inside the top module, the carry of each stage drives the T enable of the stage above it, and all stages share one clock. A chain of `STAGES` stages therefore behaves as one `4*STAGES`-bit synchronous counter and needs no extra gating. The top-level carry can feed the T enable of a further chain of the same kind.

Top module: `sync_bin_counter`

## Requirements
- R1: While `clr_n` is low at a rising edge, the count becomes 0 after that edge, whatever `load_n`, the enables and `din` are doing.
- R2: While `clr_n` is high and `load_n` is low at a rising edge, the count takes the value of `din` after that edge and does not increment.
- R3: While `clr_n` and `load_n` are high and both `cnt_en_p` and `cnt_en_t` are high at a rising edge, the full count increases by one after that edge. The count changes only at rising edges.
- R4: While `clr_n` and `load_n` are high and either enable is low at a rising edge, the count keeps its value.
- R5: `carry` is high exactly when `cnt_en_t` is high and every count bit is 1. It is combinational, and `cnt_en_p` low does not suppress it.
- R6: A count from the all-ones value wraps to 0. The low stage wraps from 1111 to 0000 and carries into the next stage.
- R7: Stage k (k > 0) increments only on an enabled edge at which all stages below it hold 1111, so the chain counts as a single binary number with stage 0 as the least significant nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state bit updates on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Count enable shared by all stages |
| cnt_en_t | input | 1 | Count enable that also qualifies the carry |
| din | input | 4*STAGES | Parallel load value; bits 3:0 go to stage 0 |
| q | output | 4*STAGES | Current count; bits 3:0 are stage 0 |
| carry | output | 1 | High when `cnt_en_t` is high and the count is all ones |

## Verification
The bench drives the controls in conflicting combinations. A clear and a load asserted together must give zero, and a load with both enables high must take `din` and not the incremented value. An inverted priority would show up as the wrong value in the count. It holds the count at all ones with `cnt_en_p` low and checks that `carry` stays high, which exposes a carry that was wrongly gated by P. It then steps across the nibble boundary and the full wrap, and runs a long count that is checked against a model. A stage that ignored the carry of the stage below it would jump by sixteen, and one that failed to wrap would leave the high nibble stuck.

// File: rtl/sync_bin_counter.sv
module sync_bin_counter_stage (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       load_n,
  input  logic       en_p,
  input  logic       en_t,
  input  logic [3:0] d,
  output logic [3:0] q,
  output logic       rco
);
  logic step;
  assign step = en_p & en_t;
  assign rco  = en_t & (&q);

  always_ff @(posedge clk) begin
    if (!clr_n)       q <= 4'd0;
    else if (!load_n) q <= d;
    else if (step)    q <= q + 4'd1;
  end

  p_clear_r1: assert property (@(posedge clk) !clr_n |=> q == 4'd0);
  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(d));
  p_count_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == $past(q) + 4'd1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));
  p_carry_gate_r5: assert property (@(posedge clk) disable iff (!clr_n)
    rco |-> en_t);
endmodule

module sync_bin_counter #(
  parameter int STAGES = 2,
  localparam int W = 4 * STAGES
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         cnt_en_p,
  input  logic         cnt_en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);
  logic [STAGES:0] t_chain;
  assign t_chain[0] = cnt_en_t;
  assign carry = t_chain[STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    sync_bin_counter_stage u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (cnt_en_p),
      .en_t   (t_chain[k]),
      .d      (din[4*k +: 4]),
      .q      (q[4*k +: 4]),
      .rco    (t_chain[k+1])
    );
  end

  p_cascade_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en_p && cnt_en_t) |=> q == $past(q) + W'(1));
  p_carry_full_r5: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (&q && cnt_en_t));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en_p && cnt_en_t && (&q)) |=> q == '0);
endmodule

// File: tb/sync_bin_counter_tb.sv
module sync_bin_counter_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic clr_n = 1'b0, load_n = 1'b1, cnt_en_p = 1'b0, cnt_en_t = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic carry;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  sync_bin_counter #(.STAGES(2)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
    .cnt_en_t(cnt_en_t), .din(din), .q(q), .carry(carry)
  );

  // row: {clr_n, load_n, p, t, din[7:0], exp_q[7:0], exp_carry}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {4'b0111, 8'h00, 8'h00, 1'b0},  // R1 reset state
    {4'b1111, 8'h00, 8'h01, 1'b0},  // R3 count
    {4'b1011, 8'h0E, 8'h0E, 1'b0},  // R2 load
    {4'b1111, 8'h00, 8'h0F, 1'b0},  // R3 low nibble full, no carry
    {4'b1111, 8'h00, 8'h10, 1'b0},  // R7 carry into high nibble
    {4'b1101, 8'h00, 8'h10, 1'b0},  // R4 P low
    {4'b1110, 8'h00, 8'h10, 1'b0},  // R4 T low
    {4'b1011, 8'hFE, 8'hFE, 1'b0},  // R2 load
    {4'b1111, 8'h00, 8'hFF, 1'b1},  // R5 carry at all ones
    {4'b1101, 8'h00, 8'hFF, 1'b1},  // R5 P low keeps carry
    {4'b1110, 8'h00, 8'hFF, 1'b0},  // R5 T low drops carry
    {4'b1111, 8'h00, 8'h00, 1'b0},  // R6 wrap
    {4'b0011, 8'h55, 8'h00, 1'b0},  // R1 clear beats load
    {4'b1011, 8'h3C, 8'h3C, 1'b0},  // R2 load beats count
    {4'b0111, 8'h00, 8'h00, 1'b0}   // R1 clear beats count
  };

  function automatic string tag_of(int i);
    case (i)
      0, 12, 14: return "R1";
      2, 7, 13:  return "R2";
      1, 3:      return "R3";
      5, 6:      return "R4";
      8, 9, 10:  return "R5";
      11:        return "R6";
      default:   return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_and_sample();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #500us;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] model;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      {clr_n, load_n, cnt_en_p, cnt_en_t, din} = VEC[i][20:9];
      step_and_sample();
      chk({tag_of(i), " q"}, 32'(q), 32'(VEC[i][8:1]));
      chk({tag_of(i), " carry"}, 32'(carry), 32'(VEC[i][0]));
    end

    // R3: count changes only at rising edges, not mid-cycle
    clr_n = 1'b1; load_n = 1'b1; cnt_en_p = 1'b1; cnt_en_t = 1'b1;
    step_and_sample();
    model = q;
    @(posedge clk); #1;
    chk("R3 mid-cycle", 32'(q), 32'(model + 8'd1));
    @(negedge clk);
    chk("R3 stable to falling edge", 32'(q), 32'(model + 8'd1));

    // R7 and R6: long run from zero through full wrap
    clr_n = 1'b0;
    step_and_sample();
    clr_n = 1'b1;
    model = '0;
    for (int n = 0; n < 300; n++) begin
      step_and_sample();
      model = model + 8'd1;
      chk("R7 chained count", 32'(q), 32'(model));
      chk("R5 carry during run", 32'(carry), 32'(model == 8'hFF));
    end

    // R7: T low on stage 0 freezes the whole chain even at x0F
    load_n = 1'b0; din = 8'h0F;
    step_and_sample();
    load_n = 1'b1; cnt_en_t = 1'b0;
    step_and_sample();
    chk("R7 T low freezes chain", 32'(q), 32'h0F);
    cnt_en_t = 1'b1;
    step_and_sample();
    chk("R7 nibble carry", 32'(q), 32'h10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule